// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Splitter

This block sits between a byte-oriented transfer source and an external memory port whose data width is not known until the access starts. A source hands it one request: a start byte address, a length of one to eight bytes, up to eight bytes of write data and an endianness flag. In the same cycle the memory reports its width through a two-bit size code. The block then issues as many column accesses as that width requires. Each access moves at most one width's worth of bytes and never crosses a width boundary.

Every access places its bytes on the correct lanes of a 64-bit data bus and raises one byte strobe per lane that carries a valid byte. Narrow memories use the low end of the bus in little-endian mode and the high end in big-endian mode. Lanes without a strobe are driven to zero. The source sees a ready signal that stays low while a split transfer is in progress. A one-cycle done pulse follows the final access. An enable input lets the memory side stall the stream of accesses.

Top module: `dbs_splitter`

## Requirements
- R1: The size code sets the widest access: code 00 allows 1 byte, 01 allows 2, 10 allows 4 and 11 allows 8. No access strobes more lanes than that.
- R2: Let o be the start address modulo the width W. A request of N bytes yields ceil((o+N)/W) accesses. Each access moves min(W - (current address mod W), bytes remaining).
- R3: The first access reports the request address on col_addr. Each following access reports the previous address plus the number of bytes the previous access moved.
- R4: In little-endian mode (req_big_endian = 0), the byte at address a goes to lane a mod W. Lane i is col_data[8i+7:8i], so a narrow memory uses only the lowest W lanes.
- R5: In big-endian mode (req_big_endian = 1), the byte at address a goes to lane 7 - (a mod W), so a narrow memory uses only the highest W lanes.
- R6: col_strb bit i is high exactly when lane i carries a valid byte. Lanes whose strobe is low read as zero. Strobes and data are all zero in cycles without col_valid.
- R7: Byte i of req_wdata (bits 8i+7:8i) is the byte for address req_addr+i.
- R8: At most one access is issued per clock. While col_enable is low during a transfer, col_valid stays low in the following cycle.
- R9: done is high for exactly one cycle, namely the cycle right after the final access's col_valid.
- R10: req_ready is low from the cycle after acceptance until the done cycle. A request held during that time starts nothing.
- R11: Under reset, req_ready is high and col_valid, done and col_strb are low.
- R12: The size code and endianness are captured when a request is accepted. Changing them during a transfer has no effect on its accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | 4 | Byte count, 1 to 8 |
| req_wdata | input | 64 | Request bytes, byte i at address req_addr+i |
| req_big_endian | input | 1 | 1 selects big-endian lane placement |
| bus_size_code | input | 2 | Memory width code sampled at acceptance |
| col_enable | input | 1 | Allows an access to issue this clock |
| col_valid | output | 1 | A column access is presented |
| col_addr | output | ADDR_W | Byte address of the access's first byte |
| col_data | output | 64 | Lane-aligned access data |
| col_strb | output | 8 | Per-lane byte strobes |
| done | output | 1 | Transfer complete pulse |

## Verification
The assertions assume the length presented with an accepted request lies between one and eight. A zero or oversize count has no meaning here, so the checker flags it as an input violation rather than as a design failure. They also assume no request is accepted before the previous transfer's done pulse, which the ready handshake enforces by itself. The stimulus draws every length from a table limited to 1 through 8. It lowers req_valid in the very cycle done is seen, so a held request cannot be taken unintentionally. It also deliberately changes the size code and endianness in mid-transfer to show that only the captured values count.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BUSY   = 2'd1,
    ST_FINISH = 2'd2
  } dbs_state_t;

  // bytes per access for a size code: 1 << code
  function automatic logic [3:0] code_to_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/dbs_chunk_calc.sv
module dbs_chunk_calc #(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 1,
  localparam int CODE_W = $clog2(CNT_W)
) (
  input  logic [CODE_W-1:0] size_code,
  input  logic [OFF_W-1:0]  addr_lo,
  input  logic [CNT_W-1:0]  remain,
  output logic [OFF_W-1:0]  offset,
  output logic [CNT_W-1:0]  take,
  output logic              last
);
  logic [CNT_W-1:0] width;
  logic [CNT_W-1:0] room;
  logic [OFF_W-1:0] mask;

  always_comb begin
    width  = CNT_W'(1) << size_code;
    mask   = OFF_W'(width - CNT_W'(1));
    offset = addr_lo & mask;
    room   = width - {1'b0, offset};
    if (remain <= room) begin
      take = remain;
      last = 1'b1;
    end else begin
      take = room;
      last = 1'b0;
    end
  end
endmodule

// File: rtl/dbs_lane_steer.sv
module dbs_lane_steer #(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 1,
  localparam int CODE_W = $clog2(CNT_W),
  localparam int DATA_W = 8 * LANES
) (
  input  logic [CODE_W-1:0] size_code,
  input  logic              big_end,
  input  logic [OFF_W-1:0]  offset,
  input  logic [CNT_W-1:0]  take,
  input  logic [CNT_W-1:0]  sent,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  strb
);
  logic [CNT_W-1:0] width;
  logic [CNT_W-1:0] win_lo;
  logic [CNT_W-1:0] win_hi;

  always_comb begin
    width  = CNT_W'(1) << size_code;
    win_lo = {1'b0, offset};
    win_hi = win_lo + take;
  end

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    localparam logic [CNT_W-1:0] POS_LE = CNT_W'(L);
    localparam logic [CNT_W-1:0] POS_BE = CNT_W'(LANES - 1 - L);
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] idx;
    logic             sel;

    always_comb begin
      pos = big_end ? POS_BE : POS_LE;
      sel = (pos < width) && (pos >= win_lo) && (pos < win_hi);
      idx = sent + (pos - win_lo);
      strb[L] = sel;
      data[8*L +: 8] = sel ? wdata[8*idx[OFF_W-1:0] +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/dbs_splitter.sv
module dbs_splitter #(
  parameter int ADDR_W = 32,
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 1,
  localparam int CODE_W = $clog2(CNT_W),
  localparam int DATA_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_big_endian,
  input  logic [CODE_W-1:0] bus_size_code,
  input  logic              col_enable,
  output logic              col_valid,
  output logic [ADDR_W-1:0] col_addr,
  output logic [DATA_W-1:0] col_data,
  output logic [LANES-1:0]  col_strb,
  output logic              done
);
  import dbs_pkg::*;

  dbs_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  remain_q;
  logic [CNT_W-1:0]  sent_q;
  logic [CODE_W-1:0] size_q;
  logic              endian_q;
  logic [DATA_W-1:0] wdata_q;
  logic              busy;

  logic [OFF_W-1:0]  cur_off;
  logic [CNT_W-1:0]  cur_take;
  logic              cur_last;
  logic [DATA_W-1:0] lane_data;
  logic [LANES-1:0]  lane_strb;

  assign busy      = (state_q == ST_BUSY);
  assign req_ready = (state_q == ST_IDLE);

  dbs_chunk_calc #(.LANES(LANES)) u_calc (
    .size_code (size_q),
    .addr_lo   (addr_q[OFF_W-1:0]),
    .remain    (remain_q),
    .offset    (cur_off),
    .take      (cur_take),
    .last      (cur_last)
  );

  dbs_lane_steer #(.LANES(LANES)) u_steer (
    .size_code (size_q),
    .big_end   (endian_q),
    .offset    (cur_off),
    .take      (cur_take),
    .sent      (sent_q),
    .wdata     (wdata_q),
    .data      (lane_data),
    .strb      (lane_strb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      remain_q  <= '0;
      sent_q    <= '0;
      size_q    <= '0;
      endian_q  <= 1'b0;
      wdata_q   <= '0;
      col_valid <= 1'b0;
      col_addr  <= '0;
      col_data  <= '0;
      col_strb  <= '0;
      done      <= 1'b0;
    end else begin
      col_valid <= 1'b0;
      col_data  <= '0;
      col_strb  <= '0;
      done      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q   <= req_addr;
            remain_q <= req_len;
            sent_q   <= '0;
            size_q   <= bus_size_code;
            endian_q <= req_big_endian;
            wdata_q  <= req_wdata;
            state_q  <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (col_enable) begin
            col_valid <= 1'b1;
            col_addr  <= addr_q;
            col_data  <= lane_data;
            col_strb  <= lane_strb;
            addr_q    <= addr_q + ADDR_W'(cur_take);
            remain_q  <= remain_q - cur_take;
            sent_q    <= sent_q + cur_take;
            if (cur_last) state_q <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbs_splitter_chk.sv
module dbs_splitter_chk #(
  parameter int ADDR_W = 32,
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 1,
  localparam int CODE_W = $clog2(CNT_W),
  localparam int DATA_W = 8 * LANES
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CNT_W-1:0]  req_len,
  input logic              col_enable,
  input logic              col_valid,
  input logic [ADDR_W-1:0] col_addr,
  input logic [DATA_W-1:0] col_data,
  input logic [LANES-1:0]  col_strb,
  input logic              done,
  input logic [CODE_W-1:0] size_q,
  input logic              endian_q,
  input logic              busy
);
  logic [CNT_W-1:0]  width;
  logic [LANES-1:0]  low_grp;
  logic [LANES-1:0]  high_grp;
  logic [DATA_W-1:0] byte_mask;

  always_comb begin
    width    = CNT_W'(1) << size_q;
    low_grp  = LANES'((1 << width) - 1);
    high_grp = ~(LANES'({LANES{1'b1}} >> width));
    for (int i = 0; i < LANES; i++) byte_mask[8*i +: 8] = {8{col_strb[i]}};
  end

  AST_STRB_WIDTH: assert property (@(posedge clk) disable iff (rst)
    col_valid |-> (col_strb != '0) && ($countones(col_strb) <= int'(width))); // R1
  AST_LE_LOW_LANES: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !endian_q) |-> ((col_strb & ~low_grp) == '0)); // R4
  AST_BE_HIGH_LANES: assert property (@(posedge clk) disable iff (rst)
    (col_valid && endian_q) |-> ((col_strb & ~high_grp) == '0)); // R5
  AST_OFF_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
    col_valid |-> ((col_data & ~byte_mask) == '0)); // R6
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !col_valid |-> (col_strb == '0) && (col_data == '0)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (col_valid && $past(col_valid)) |->
      (col_addr == $past(col_addr) + ADDR_W'($countones($past(col_strb))))); // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && !col_enable) |=> !col_valid); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(col_valid)); // R9
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (rst)
    col_valid |-> !req_ready); // R10
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> (req_len != '0) && (req_len <= CNT_W'(LANES))); // R2
endmodule

bind dbs_splitter dbs_splitter_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_len    (req_len),
  .col_enable (col_enable),
  .col_valid  (col_valid),
  .col_addr   (col_addr),
  .col_data   (col_data),
  .col_strb   (col_strb),
  .done       (done),
  .size_q     (size_q),
  .endian_q   (endian_q),
  .busy       (busy)
);

// File: tb/tb_dbs_splitter.sv
module tb_dbs_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [3:0]  req_len;
  logic [63:0] req_wdata;
  logic        req_big_endian;
  logic [1:0]  bus_size_code;
  logic        col_enable;
  logic        col_valid;
  logic [31:0] col_addr;
  logic [63:0] col_data;
  logic [7:0]  col_strb;
  logic        done;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbs_splitter dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .req_big_endian(req_big_endian), .bus_size_code(bus_size_code),
    .col_enable(col_enable), .col_valid(col_valid), .col_addr(col_addr),
    .col_data(col_data), .col_strb(col_strb), .done(done)
  );

  // fields: addr[106:75] len[74:71] code[70:69] be[68] wdata[67:4] accesses[3:0]
  localparam logic [106:0] VECS [NVEC] = '{
    {32'h0000_1000, 4'd8, 2'b11, 1'b0, 64'h8877_6655_4433_2211, 4'd1},
    {32'h0000_1003, 4'd8, 2'b11, 1'b0, 64'hF0E1_D2C3_B4A5_9687, 4'd2},
    {32'h0000_2000, 4'd8, 2'b10, 1'b0, 64'h0102_0304_0506_0708, 4'd2},
    {32'h0000_2002, 4'd5, 2'b10, 1'b1, 64'h0000_00AA_BBCC_DDEE, 4'd2},
    {32'h0000_3001, 4'd4, 2'b01, 1'b0, 64'h0000_0000_1357_9BDF, 4'd3},
    {32'h0000_3000, 4'd8, 2'b00, 1'b1, 64'h1122_3344_5566_7788, 4'd8},
    {32'h0000_4005, 4'd1, 2'b00, 1'b0, 64'h0000_0000_0000_005A, 4'd1},
    {32'h0000_4007, 4'd2, 2'b11, 1'b1, 64'h0000_0000_0000_C3A5, 4'd2},
    {32'h0000_5006, 4'd3, 2'b01, 1'b1, 64'h0000_0000_0077_6655, 4'd2},
    {32'h0000_6001, 4'd7, 2'b10, 1'b1, 64'h00A1_B2C3_D4E5_F607, 4'd2},
    {32'h0000_7002, 4'd6, 2'b11, 1'b0, 64'h0000_9988_7766_5544, 4'd1}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic run_xfer(input logic [31:0] addr, input logic [3:0] len, input logic [1:0] code,
                          input logic be, input logic [63:0] wd, input int exp_cnt,
                          input bit stall, input bit poke);
    int w = 1 << code;
    logic [31:0] cur = addr;
    int rem = len;
    int sent = 0;
    int got = 0;
    int guard = 0;
    bit prev_v = 0;
    @(negedge clk);
    req_addr = addr; req_len = len; req_wdata = wd;
    req_big_endian = be; bus_size_code = code; req_valid = 1'b1;
    col_enable = !stall;
    @(negedge clk);
    // R12: disturb captured settings mid-transfer
    bus_size_code = ~code; req_big_endian = ~be;
    if (poke) begin
      req_addr = 32'hDEAD_0000; req_len = 4'd8;
    end else req_valid = 1'b0;
    if (stall) begin
      for (int s = 0; s < 3; s++) begin
        chk(col_valid == 1'b0, "R8 stalled access", {63'd0, col_valid}, 64'd0);
        chk(req_ready == 1'b0, "R10 ready during stall", {63'd0, req_ready}, 64'd0);
        @(negedge clk);
      end
      col_enable = 1'b1;
    end
    while (1) begin
      if (col_valid) begin
        logic [63:0] ed = '0;
        logic [7:0]  es = '0;
        int o = int'(cur) % w;
        int m = (w - o < rem) ? (w - o) : rem;
        for (int j = 0; j < m; j++) begin
          int k = o + j;
          int lane = be ? 7 - k : k;
          es[lane] = 1'b1;
          ed[8*lane +: 8] = wd[8*(sent+j) +: 8];
        end
        chk(col_addr == cur, "R3 access address", {32'd0, col_addr}, {32'd0, cur});
        chk(col_strb == es, "R1 R2 R4 R5 R6 R12 strobes", {56'd0, col_strb}, {56'd0, es});
        chk(col_data == ed, "R4 R5 R6 R7 R12 data", col_data, ed);
        cur = cur + 32'(m); rem -= m; sent += m; got++;
      end
      if (done) begin
        chk(prev_v == 1'b1, "R9 done follows last access", {63'd0, prev_v}, 64'd1);
        chk(got == exp_cnt, "R2 access count", 64'(got), 64'(exp_cnt));
        chk(req_ready == 1'b1, "R10 ready with done", {63'd0, req_ready}, 64'd1);
        req_valid = 1'b0;
        break;
      end
      chk(req_ready == 1'b0, "R10 ready low while busy", {63'd0, req_ready}, 64'd0);
      prev_v = col_valid;
      guard++;
      if (guard > 64) begin
        chk(1'b0, "R9 done never seen", 64'd0, 64'd1);
        req_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", {63'd0, done}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_len = 4'd1; req_wdata = '0;
    req_big_endian = 1'b0; bus_size_code = 2'b11; col_enable = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 reset ready", {63'd0, req_ready}, 64'd1);
    chk(col_valid == 1'b0, "R11 reset col_valid", {63'd0, col_valid}, 64'd0);
    chk(done == 1'b0, "R11 reset done", {63'd0, done}, 64'd0);
    chk(col_strb == 8'h00, "R11 reset strobes", {56'd0, col_strb}, 64'd0);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      run_xfer(VECS[v][106:75], VECS[v][74:71], VECS[v][70:69], VECS[v][68],
               VECS[v][67:4], int'(VECS[v][3:0]), 1'b0, 1'b0);
    end

    // R8: stalled start, byte-wide little-endian
    run_xfer(32'h0000_8002, 4'd3, 2'b00, 1'b0, 64'h0000_0000_00CC_BBAA, 3, 1'b1, 1'b0);
    // R10: request held during a transfer is ignored
    run_xfer(32'h0000_9001, 4'd5, 2'b01, 1'b0, 64'h0000_0055_4433_2211, 3, 1'b0, 1'b1);
    for (int c = 0; c < 4; c++) begin
      chk(col_valid == 1'b0, "R10 held request started nothing", {63'd0, col_valid}, 64'd0);
      chk(req_ready == 1'b1, "R10 idle after done", {63'd0, req_ready}, 64'd1);
      @(negedge clk);
    end
    finish_run();
  end
endmodule